// File: doc/BRIEF.md
# Boot ROM overlay address decoder

This block sits between the processor bus of a small 8-bit machine (16-bit address, separate memory and I/O strobes) and its memories and peripherals. It drives the chip selects for RAM, the boot ROM, the monitor ROM, an interval timer and two serial ports. It also drives a 12-bit address into a shared 4 KB ROM space, where the boot code fills the lower 2 KB and the monitor fills the upper 2 KB. It steers the read data of the selected source back to the processor. A read that no device claims returns zero.

An 8-bit addressable control latch sits behind one write-only I/O port. Each write changes a single latch bit. Both the bit number and the value are sent inverted in the low nibble of the data byte. Two of the latch bits shape the memory map. An active-low boot-select bit enables the boot ROM overlay. An active-low startup bit also mirrors the boot ROM at address zero, so that the processor finds code there when it leaves reset. Software clears the overlay in two steps. It first releases the low copy and later, if it wants, the high window too. All eight latch bits are brought out so that other board logic can use them.

Top module: `boot_overlay_decoder`

## Requirements
- R1: An I/O write (ioWr) with addr[7:0] = 0xFF changes latch bit number ~wrData[2:0] to the value ~wrData[3] on that clock edge. Example: 0x04 sets bit 3, 0x0C clears bit 3, 0x02 sets bit 5, 0x07 sets bit 0 and 0x00 sets bit 7. The other bits keep their values, and an I/O write to any other port leaves the latch unchanged.
- R2: Reset clears all eight latch bits, so that both boot ROM windows are active right after reset.
- R3: With latch bit 3 = 0 and bit 5 = 0, a memory read of 0x0000–0x07FF or of 0xE800–0xEFFF asserts bootRomCs, and romAddr = {1'b0, addr[10:0]} in both windows.
- R4: With bit 3 = 0 and bit 5 = 1, the boot ROM answers only at 0xE800–0xEFFF, and 0x0000–0x07FF selects RAM.
- R5: With bit 3 = 1, bootRomCs is never asserted. The whole range 0x0000–0xEFFF goes to RAM where RAM exists and is unmapped elsewhere.
- R6: A memory read of 0xF800–0xFFFF asserts monRomCs in every latch state, with romAddr = {1'b1, addr[10:0]}.
- R7: With BIG_RAM = 0, RAM covers only 0x0000–0x7FFF. With BIG_RAM = 1, RAM covers every address where no ROM is mapped.
- R8: The ROM selects respond only to memRd. ramCs responds to memRd or memWr. A memory write into an active ROM window asserts no select.
- R9: The I/O decode uses only addr[7:0], on ioRd or ioWr. Ports 0xF0–0xF3 select the timer, 0xF4–0xF5 select serial port 1 and 0xF6–0xF7 select serial port 2. No other port selects a device.
- R10: Port 0xFF is write-only. An I/O read of it asserts no select and returns 0x00.
- R11: During memRd or ioRd, rdData carries the input of the selected source: ramRdData, romRdData for either ROM, timerRdData, ser1RdData or ser2RdData. It is 0x00 when no source is selected and whenever no read strobe is active.
- R12: With at most one bus strobe active, at most one chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Bus address |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| wrData | input | 8 | Processor write data |
| ramRdData | input | 8 | Read data from RAM |
| romRdData | input | 8 | Read data from the 4 KB ROM space |
| timerRdData | input | 8 | Read data from the timer |
| ser1RdData | input | 8 | Read data from serial port 1 |
| ser2RdData | input | 8 | Read data from serial port 2 |
| rdData | output | 8 | Read data to the processor |
| ramCs | output | 1 | RAM select |
| bootRomCs | output | 1 | Boot ROM select |
| monRomCs | output | 1 | Monitor ROM select |
| romAddr | output | 12 | Address into the 4 KB ROM space |
| timerCs | output | 1 | Timer select |
| ser1Cs | output | 1 | Serial port 1 select |
| ser2Cs | output | 1 | Serial port 2 select |
| latchQ | output | 8 | Control latch outputs |

## Verification
The bench builds two copies of the decoder on the same bus. One uses the default BIG_RAM = 0 and the other uses BIG_RAM = 1, and every vector carries an expected select set for each copy. With both copies, the addresses 0x8000–0xF7FF, including the 0xE800 window once the overlay is off, are checked as unmapped in one copy and as RAM in the other. The bench steps the latch through all three overlay states and then writes bits away from 3 and 5. This brings the inverted index and value encoding, bit 0 and bit 7, and a write to a neighbouring port within reach.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int ROM_AW  = 11;
  localparam int PAGE_W  = ADDR_W - ROM_AW;
  localparam int IO_AW   = 8;

  localparam logic [PAGE_W-1:0] LOW_PAGE  = '0;
  localparam logic [PAGE_W-1:0] BOOT_PAGE = PAGE_W'(16'hE800 >> ROM_AW);
  localparam logic [PAGE_W-1:0] MON_PAGE  = '1;

  localparam logic [IO_AW-1:0] CTRL_PORT  = 8'hFF;
  localparam logic [IO_AW-1:0] TIMER_BASE = 8'hF0;
  localparam logic [IO_AW-1:0] SER1_BASE  = 8'hF4;
  localparam logic [IO_AW-1:0] SER2_BASE  = 8'hF6;

  typedef struct packed {
    logic bootHighEn;
    logic bootLowEn;
    logic timerSel;
    logic ser1Sel;
    logic ser2Sel;
  } ctrlStrobes_t;
endpackage

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_overlay_pkg::*;
#(
  parameter int LATCH_W      = 8,
  parameter int BOOT_SEL_BIT = 3,
  parameter int START_BIT    = 5,
  localparam int IDX_W       = $clog2(LATCH_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IO_AW-1:0]   ioAddr,
  input  logic               ioRd,
  input  logic               ioWr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [LATCH_W-1:0] latchQ,
  output ctrlStrobes_t       strobes
);
  logic             ioActive;
  logic             latchWe;
  logic [IDX_W-1:0] latchIdx;
  logic             latchVal;
  logic [DATA_W-IDX_W-2:0] unusedDataBits;

  assign ioActive = ioRd | ioWr;
  assign latchWe  = ioWr && (ioAddr == CTRL_PORT);
  assign latchIdx = ~wrData[IDX_W-1:0];
  assign latchVal = ~wrData[IDX_W];
  assign unusedDataBits = wrData[DATA_W-1:IDX_W+1];

  for (genvar i = 0; i < LATCH_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        latchQ[i] <= 1'b0;
      else if (latchWe && (latchIdx == IDX_W'(i)))
        latchQ[i] <= latchVal;
    end
  end

  always_comb begin
    strobes.bootHighEn = !latchQ[BOOT_SEL_BIT];
    strobes.bootLowEn  = !latchQ[BOOT_SEL_BIT] && !latchQ[START_BIT];
    strobes.timerSel   = ioActive && (ioAddr[IO_AW-1:2] == TIMER_BASE[IO_AW-1:2]);
    strobes.ser1Sel    = ioActive && (ioAddr[IO_AW-1:1] == SER1_BASE[IO_AW-1:1]);
    strobes.ser2Sel    = ioActive && (ioAddr[IO_AW-1:1] == SER2_BASE[IO_AW-1:1]);
  end
endmodule

// File: rtl/boot_overlay_datapath.sv
module boot_overlay_datapath
  import boot_overlay_pkg::*;
#(
  parameter bit BIG_RAM = 1'b0
) (
  input  logic              [ADDR_W-1:0] addr,
  input  logic                           memRd,
  input  logic                           memWr,
  input  logic                           ioRd,
  input  ctrlStrobes_t                   strobes,
  input  logic              [DATA_W-1:0] ramRdData,
  input  logic              [DATA_W-1:0] romRdData,
  input  logic              [DATA_W-1:0] timerRdData,
  input  logic              [DATA_W-1:0] ser1RdData,
  input  logic              [DATA_W-1:0] ser2RdData,
  output logic              [DATA_W-1:0] rdData,
  output logic                           ramCs,
  output logic                           bootRomCs,
  output logic                           monRomCs,
  output logic              [ROM_AW:0]   romAddr,
  output logic                           timerCs,
  output logic                           ser1Cs,
  output logic                           ser2Cs
);
  logic [PAGE_W-1:0] page;
  logic inLow, inBoot, inMon;
  logic bootHit, romHit, ramRange, memActive;

  assign page   = addr[ADDR_W-1:ROM_AW];
  assign inLow  = (page == LOW_PAGE);
  assign inBoot = (page == BOOT_PAGE);
  assign inMon  = (page == MON_PAGE);

  assign bootHit = (strobes.bootHighEn && inBoot) || (strobes.bootLowEn && inLow);
  assign romHit  = bootHit || inMon;

  if (BIG_RAM) begin : g_big_ram
    assign ramRange = 1'b1;
  end else begin : g_small_ram
    assign ramRange = !addr[ADDR_W-1];
  end

  assign memActive = memRd | memWr;
  assign ramCs     = memActive && ramRange && !romHit;
  assign bootRomCs = memRd && bootHit;
  assign monRomCs  = memRd && inMon;
  assign romAddr   = {inMon, addr[ROM_AW-1:0]};
  assign timerCs   = strobes.timerSel;
  assign ser1Cs    = strobes.ser1Sel;
  assign ser2Cs    = strobes.ser2Sel;

  always_comb begin
    rdData = '0;
    if (memRd) begin
      if (bootRomCs || monRomCs) rdData = romRdData;
      else if (ramCs)            rdData = ramRdData;
    end else if (ioRd) begin
      if (timerCs)     rdData = timerRdData;
      else if (ser1Cs) rdData = ser1RdData;
      else if (ser2Cs) rdData = ser2RdData;
    end
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_overlay_pkg::*;
#(
  parameter bit BIG_RAM      = 1'b0,
  parameter int LATCH_W      = 8,
  parameter int BOOT_SEL_BIT = 3,
  parameter int START_BIT    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        addr,
  input  logic               memRd,
  input  logic               memWr,
  input  logic               ioRd,
  input  logic               ioWr,
  input  logic [7:0]         wrData,
  input  logic [7:0]         ramRdData,
  input  logic [7:0]         romRdData,
  input  logic [7:0]         timerRdData,
  input  logic [7:0]         ser1RdData,
  input  logic [7:0]         ser2RdData,
  output logic [7:0]         rdData,
  output logic               ramCs,
  output logic               bootRomCs,
  output logic               monRomCs,
  output logic [11:0]        romAddr,
  output logic               timerCs,
  output logic               ser1Cs,
  output logic               ser2Cs,
  output logic [LATCH_W-1:0] latchQ
);
  ctrlStrobes_t strobes;

  boot_overlay_ctrl #(
    .LATCH_W(LATCH_W), .BOOT_SEL_BIT(BOOT_SEL_BIT), .START_BIT(START_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(addr[IO_AW-1:0]), .ioRd(ioRd), .ioWr(ioWr),
    .wrData(wrData), .latchQ(latchQ), .strobes(strobes)
  );

  boot_overlay_datapath #(.BIG_RAM(BIG_RAM)) u_dp (
    .addr(addr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .strobes(strobes),
    .ramRdData(ramRdData), .romRdData(romRdData), .timerRdData(timerRdData),
    .ser1RdData(ser1RdData), .ser2RdData(ser2RdData), .rdData(rdData),
    .ramCs(ramCs), .bootRomCs(bootRomCs), .monRomCs(monRomCs), .romAddr(romAddr),
    .timerCs(timerCs), .ser1Cs(ser1Cs), .ser2Cs(ser2Cs)
  );
endmodule

// File: rtl/boot_overlay_checker.sv
module boot_overlay_checker #(
  parameter int LATCH_W      = 8,
  parameter int BOOT_SEL_BIT = 3,
  localparam int IDX_W       = $clog2(LATCH_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic [15:0]        addr,
  input logic               memRd,
  input logic               memWr,
  input logic               ioRd,
  input logic               ioWr,
  input logic [IDX_W:0]     ctrlNibble,
  input logic [LATCH_W-1:0] latchQ,
  input logic               ramCs,
  input logic               bootRomCs,
  input logic               monRomCs,
  input logic               timerCs,
  input logic               ser1Cs,
  input logic               ser2Cs,
  input logic [7:0]         rdData
);
  logic ctrlWrite;
  logic [2:0] unusedAddrBits;
  assign ctrlWrite = ioWr && (addr[7:0] == 8'hFF);
  assign unusedAddrBits = addr[10:8];

  // R1: addressed bit takes the inverted data bit
  p_latch_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> latchQ[IDX_W'(~$past(ctrlNibble[IDX_W-1:0]))] == ~$past(ctrlNibble[IDX_W]));

  // R1: no control write, no latch change
  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(latchQ));

  p_boot_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    latchQ[BOOT_SEL_BIT] |-> !bootRomCs);

  p_mon_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && addr[15:11] == 5'h1F) |-> monRomCs);

  p_rom_read_only_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bootRomCs || monRomCs) |-> memRd);

  p_ctrl_port_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !memRd && addr[7:0] == 8'hFF) |-> (rdData == 8'h00 && !timerCs && !ser1Cs && !ser2Cs));

  p_open_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !ioRd && !ramCs && !bootRomCs && !monRomCs) |-> rdData == 8'h00);

  p_single_select_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWr, ioRd, ioWr}) |->
      $onehot0({ramCs, bootRomCs, monRomCs, timerCs, ser1Cs, ser2Cs}));
endmodule

bind boot_overlay_decoder boot_overlay_checker #(
  .LATCH_W(LATCH_W), .BOOT_SEL_BIT(BOOT_SEL_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr),
  .ioRd(ioRd), .ioWr(ioWr), .ctrlNibble(wrData[$clog2(LATCH_W):0]), .latchQ(latchQ),
  .ramCs(ramCs), .bootRomCs(bootRomCs), .monRomCs(monRomCs), .timerCs(timerCs),
  .ser1Cs(ser1Cs), .ser2Cs(ser2Cs), .rdData(rdData)
);

// File: tb/boot_overlay_decoder_tb.sv
module boot_overlay_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] addr = '0;
  logic memRd = 0, memWr = 0, ioRd = 0, ioWr = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdS, rdB;
  logic ramS, bootS, monS, tmrS, s1S, s2S;
  logic ramB, bootB, monB, tmrB, s1B, s2B;
  logic [11:0] romAS, romAB;
  logic [7:0] latchS, latchB;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_overlay_decoder u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd),
    .ioWr(ioWr), .wrData(wrData), .ramRdData(8'h11), .romRdData(8'h22),
    .timerRdData(8'h33), .ser1RdData(8'h44), .ser2RdData(8'h55), .rdData(rdS),
    .ramCs(ramS), .bootRomCs(bootS), .monRomCs(monS), .romAddr(romAS),
    .timerCs(tmrS), .ser1Cs(s1S), .ser2Cs(s2S), .latchQ(latchS));

  boot_overlay_decoder #(.BIG_RAM(1'b1)) u_dut_big (
    .clk(clk), .rstN(rstN), .addr(addr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd),
    .ioWr(ioWr), .wrData(wrData), .ramRdData(8'h11), .romRdData(8'h22),
    .timerRdData(8'h33), .ser1RdData(8'h44), .ser2RdData(8'h55), .rdData(rdB),
    .ramCs(ramB), .bootRomCs(bootB), .monRomCs(monB), .romAddr(romAB),
    .timerCs(tmrB), .ser1Cs(s1B), .ser2Cs(s2B), .latchQ(latchB));

  // select vector order: {ram, boot, mon, timer, ser1, ser2}
  typedef struct packed {
    logic [1:0]  mode;   // 0: both windows, 1: high only, 2: overlay off
    logic [15:0] adr;
    logic [1:0]  op;     // 0 memRd, 1 memWr, 2 ioRd, 3 ioWr
    logic [5:0]  expS;
    logic [5:0]  expB;
    logic [11:0] romA;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VECS [NVEC] = '{
    // R3 startup map
    '{2'd0, 16'h0000, 2'd0, 6'b010000, 6'b010000, 12'h000},
    '{2'd0, 16'h07FF, 2'd0, 6'b010000, 6'b010000, 12'h7FF},
    '{2'd0, 16'h0800, 2'd0, 6'b100000, 6'b100000, 12'h000},
    '{2'd0, 16'hE800, 2'd0, 6'b010000, 6'b010000, 12'h000},
    '{2'd0, 16'hEFFF, 2'd0, 6'b010000, 6'b010000, 12'h7FF},
    // R6 monitor
    '{2'd0, 16'hF800, 2'd0, 6'b001000, 6'b001000, 12'h800},
    '{2'd0, 16'hFFFF, 2'd0, 6'b001000, 6'b001000, 12'hFFF},
    // R8 write into ROM window / RAM write
    '{2'd0, 16'h0000, 2'd1, 6'b000000, 6'b000000, 12'h000},
    '{2'd0, 16'h7FFF, 2'd1, 6'b100000, 6'b100000, 12'h000},
    // R7 RAM size
    '{2'd0, 16'h8000, 2'd0, 6'b000000, 6'b100000, 12'h000},
    '{2'd0, 16'hF000, 2'd0, 6'b000000, 6'b100000, 12'h000},
    // R9 I/O decode
    '{2'd0, 16'h00F0, 2'd2, 6'b000100, 6'b000100, 12'h000},
    '{2'd0, 16'h00F3, 2'd3, 6'b000100, 6'b000100, 12'h000},
    '{2'd0, 16'h00F4, 2'd2, 6'b000010, 6'b000010, 12'h000},
    '{2'd0, 16'h00F5, 2'd3, 6'b000010, 6'b000010, 12'h000},
    '{2'd0, 16'h00F6, 2'd2, 6'b000001, 6'b000001, 12'h000},
    '{2'd0, 16'h00F7, 2'd2, 6'b000001, 6'b000001, 12'h000},
    '{2'd0, 16'h00F8, 2'd2, 6'b000000, 6'b000000, 12'h000},
    '{2'd0, 16'h00EF, 2'd2, 6'b000000, 6'b000000, 12'h000},
    '{2'd0, 16'h0000, 2'd2, 6'b000000, 6'b000000, 12'h000},
    // R4 startup released
    '{2'd1, 16'h0000, 2'd0, 6'b100000, 6'b100000, 12'h000},
    '{2'd1, 16'h07FF, 2'd1, 6'b100000, 6'b100000, 12'h000},
    '{2'd1, 16'hE800, 2'd0, 6'b010000, 6'b010000, 12'h000},
    '{2'd1, 16'hEFFF, 2'd0, 6'b010000, 6'b010000, 12'h7FF},
    '{2'd1, 16'hF800, 2'd0, 6'b001000, 6'b001000, 12'h800},
    // R5 overlay off
    '{2'd2, 16'h0000, 2'd0, 6'b100000, 6'b100000, 12'h000},
    '{2'd2, 16'hE800, 2'd0, 6'b000000, 6'b100000, 12'h000},
    '{2'd2, 16'hEFFF, 2'd1, 6'b000000, 6'b100000, 12'h000},
    '{2'd2, 16'hF800, 2'd0, 6'b001000, 6'b001000, 12'h800},
    '{2'd2, 16'hFFFF, 2'd1, 6'b000000, 6'b000000, 12'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [5:0] cs, input logic isRead);
    if (!isRead)    return 8'h00;
    if (cs[5])      return 8'h11;
    if (cs[4]|cs[3]) return 8'h22;
    if (cs[2])      return 8'h33;
    if (cs[1])      return 8'h44;
    if (cs[0])      return 8'h55;
    return 8'h00;
  endfunction

  task automatic idle();
    memRd = 0; memWr = 0; ioRd = 0; ioWr = 0;
  endtask

  task automatic apply(input logic [15:0] a, input logic [1:0] op);
    @(negedge clk);
    idle();
    addr = a;
    case (op)
      2'd0: memRd = 1;
      2'd1: memWr = 1;
      2'd2: ioRd = 1;
      default: ioWr = 1;
    endcase
    #1;
  endtask

  task automatic ctrlWrite(input logic [7:0] port, input logic [7:0] d);
    @(negedge clk);
    idle();
    addr = {8'h00, port};
    wrData = d;
    ioWr = 1;
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] curMode;
    string req;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R2 latch reset", {24'h0, latchS}, 32'h00);
    curMode = 2'd0;
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].mode != curMode) begin
        // mode 1: set bit 5 (0x02); mode 2: set bit 3 (0x04)
        ctrlWrite(8'hFF, (VECS[i].mode == 2'd1) ? 8'h02 : 8'h04);
        curMode = VECS[i].mode;
      end
      apply(VECS[i].adr, VECS[i].op);
      case (curMode)
        2'd0: req = "R3";
        2'd1: req = "R4";
        default: req = "R5";
      endcase
      chk({req, " R9 R12 selects small"}, {26'h0, ramS, bootS, monS, tmrS, s1S, s2S},
          {26'h0, VECS[i].expS});
      chk("R7 selects big", {26'h0, ramB, bootB, monB, tmrB, s1B, s2B}, {26'h0, VECS[i].expB});
      chk("R11 rdData small", {24'h0, rdS},
          {24'h0, expRd(VECS[i].expS, (VECS[i].op == 2'd0) || (VECS[i].op == 2'd2))});
      chk("R11 rdData big", {24'h0, rdB},
          {24'h0, expRd(VECS[i].expB, (VECS[i].op == 2'd0) || (VECS[i].op == 2'd2))});
      if (VECS[i].expS[4] || VECS[i].expS[3])
        chk("R3 R6 romAddr", {20'h0, romAS}, {20'h0, VECS[i].romA});
    end

    chk("R1 latch after two writes", {24'h0, latchS}, 32'h28);
    ctrlWrite(8'hFF, 8'h0C);
    chk("R1 clear bit 3", {24'h0, latchS}, 32'h20);
    apply(16'hE800, 2'd0);
    chk("R1 R4 boot window back", {31'h0, bootS}, 32'h1);
    ctrlWrite(8'hFF, 8'h07);
    chk("R1 set bit 0", {24'h0, latchS}, 32'h21);
    ctrlWrite(8'hFF, 8'h00);
    chk("R1 set bit 7", {24'h0, latchB}, 32'hA1);
    ctrlWrite(8'hFF, 8'h08);
    chk("R1 clear bit 7", {24'h0, latchS}, 32'h21);
    ctrlWrite(8'hFE, 8'h04);
    chk("R1 other port ignored", {24'h0, latchS}, 32'h21);
    apply(16'hE800, 2'd0);
    chk("R1 overlay kept after other port", {31'h0, bootS}, 32'h1);

    apply(16'h00FF, 2'd2);
    chk("R10 ctrl port read data", {24'h0, rdS}, 32'h00);
    chk("R10 ctrl port no select", {29'h0, tmrS, s1S, s2S}, 32'h0);
    apply(16'h12F4, 2'd2);
    chk("R9 high address bits ignored", {29'h0, tmrS, s1S, s2S}, 32'h2);
    chk("R11 ser1 read", {24'h0, rdS}, 32'h44);
    apply(16'hF800, 2'd1);
    chk("R8 monitor write no select", {29'h0, ramB, monB, bootB}, 32'h0);

    @(negedge clk);
    idle();
    rstN = 0;
    #1;
    chk("R2 reset clears latch", {24'h0, latchS}, 32'h00);
    @(negedge clk);
    rstN = 1;
    apply(16'h0000, 2'd0);
    chk("R2 low boot window after reset", {31'h0, bootS}, 32'h1);
    chk("R2 romAddr low window", {20'h0, romAS}, 32'h000);
    @(negedge clk);
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule